// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block arbitrates twelve interrupt sources for a small processor core. Every source owns a pending flag, an enable bit and a priority bit that selects one of two levels. Each clock the enabled pending flags are examined, and the strongest eligible request is captured in a detect register. When the core reports an instruction boundary, a fixed call sequence runs. At its end the block pulses a take strobe together with the source's 16-bit vector address and marks that source's level as in service.

Two in-service flags record which levels are active. They decide whether a new request may nest. A high-level request may interrupt a low-level routine, but nothing interrupts a high-level routine. The core reports a completed return-from-interrupt on a separate strobe. That strobe clears the top active level, and it never counts as a call boundary, so one more instruction always completes before the next vector call.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset all pending, enable and priority bits and the global enable are 0, both in-service flags are 0, and `take_o` and `ret_o` are low. With nothing pending, no vector is taken.
- R2: A pending flag is set by a pulse on its `evt_i` bit or by a software write with `wr_sel`=0, which loads all twelve flags from `wr_data`. A pending flag whose enable bit is 0 (`wr_sel`=1) raises no request but stays set, and it is taken once its enable is written to 1.
- R3: With `insn_done` held high and nothing in service, `take_o` first rises in the cycle after the 5th rising edge following the edge that registers the pending flag. `take_o` is a one-cycle pulse.
- R4: During `take_o`, `vec_o` equals 0x0003 + 8 × source index and `lvl_o` gives the source's level (1 = high).
- R5: Priority bits are written with `wr_sel`=2 (bit i = 1 puts source i at the high level). Among requests recognised together, a high-level one is taken before any low-level one, whatever the indices.
- R6: Within one level, the lowest source index is taken first.
- R7: Taking a vector clears that source's pending flag, so one set of a flag produces exactly one take.
- R8: `insvc_o` bit 0 marks the low level in service and bit 1 the high level. A take sets the bit for its level. A `reti` pulse clears bit 1 if it is set, otherwise bit 0, and `ret_o` pulses in the following cycle when a bit was set.
- R9: While a low-level routine is in service, a high-level request is taken and a low-level one waits. While a high-level routine is in service, no request is taken.
- R10: A cycle with `reti` high never starts a call, even when `insn_done` is high. After a return, a waiting request starts its call on the next `insn_done` pulse. With `insn_done` held high, its take therefore comes 4 edges after the return edge.
- R11: A call starts only on a cycle with `insn_done` high, and the take follows 3 rising edges after that start edge.
- R12: The global enable, written with `wr_sel`=3 from `wr_data[0]`, gates all requests. While it is 0 nothing is taken, and pending flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 pending, 1 enable, 2 priority, 3 global enable |
| wr_data | input | 12 | Write data, bit i for source i |
| evt_i | input | 12 | Hardware event pulses that set pending flags |
| insn_done | input | 1 | Instruction boundary strobe from the core |
| reti | input | 1 | Return-from-interrupt completed strobe |
| take_o | output | 1 | One-cycle vector-take strobe |
| vec_o | output | 16 | Vector address, valid with `take_o` |
| lvl_o | output | 1 | Level of the taken source, valid with `take_o` |
| insvc_o | output | 2 | In-service flags (bit 1 high, bit 0 low) |
| ret_o | output | 1 | Pulses one cycle after a return that cleared a level |

## Verification
The properties assume a well-behaved core. It never pulses `reti` while a call sequence is running, and it pulses `reti` only from inside a service routine. Under those conditions the in-service flags change only at a take or a return, which the nesting and return-order properties depend on. Every bench scenario issues returns only after a take has been observed and only between calls. Boundary strobes are either held high or pulsed for a single cycle at chosen points, so each call start falls on a known edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC = 12;
    localparam int IDXW = $clog2(NSRC);
    localparam int NLVL = 2;
    localparam int VECW = 16;

    typedef logic [NSRC-1:0] src_vec_t;
    typedef logic [IDXW-1:0] src_idx_t;

    typedef enum logic [1:0] {
        WS_PEND   = 2'd0,
        WS_MASK   = 2'd1,
        WS_LEVEL  = 2'd2,
        WS_MASTER = 2'd3
    } wsel_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_CALL = 1'b1
    } sq_state_e;

    typedef struct packed {
        logic     valid;
        logic     hi;
        src_idx_t idx;
    } pick_t;

    // lowest set index wins
    function automatic pick_t first_set(input src_vec_t m, input logic hi);
        pick_t p;
        p    = '0;
        p.hi = hi;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (m[i]) begin
                p.valid = 1'b1;
                p.idx   = src_idx_t'(i);
            end
        end
        return p;
    endfunction

    function automatic logic [VECW-1:0] vec_of(input src_idx_t idx,
                                               input logic [VECW-1:0] base,
                                               input int step);
        return base + VECW'(step) * VECW'(idx);
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  wsel_e    wr_sel,
    input  src_vec_t wr_data,
    input  src_vec_t evt,
    input  src_vec_t clr,
    output src_vec_t pend_q,
    output src_vec_t en_q,
    output src_vec_t prio_q,
    output logic     gie_q
);

    src_vec_t pend_base;

    always_comb begin
        pend_base = (wr_en && wr_sel == WS_PEND) ? wr_data : pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            en_q   <= '0;
            prio_q <= '0;
            gie_q  <= 1'b0;
        end else begin
            // a new event wins over the clear of the taken source
            pend_q <= (pend_base & ~clr) | evt;
            if (wr_en) begin
                case (wr_sel)
                    WS_MASK:   en_q   <= wr_data;
                    WS_LEVEL:  prio_q <= wr_data;
                    WS_MASTER: gie_q  <= wr_data[0];
                    default:   ;
                endcase
            end
        end
    end

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
    import irqc_pkg::*;
(
    input  src_vec_t        pend,
    input  src_vec_t        en,
    input  src_vec_t        prio,
    input  logic            gie,
    input  logic [NLVL-1:0] busy,
    output pick_t           win
);

    src_vec_t req;
    pick_t    lvl_pick [NLVL];

    assign req = pend & en & {NSRC{gie}};

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        src_vec_t lmask;
        logic     open_l;
        assign lmask  = (l == NLVL - 1) ? (req & prio) : (req & ~prio);
        // a level may start only if neither it nor a higher one is active
        assign open_l = ~|busy[NLVL-1:l];
        assign lvl_pick[l] = open_l ? first_set(lmask, (l == NLVL - 1)) : '0;
    end

    always_comb begin
        win = lvl_pick[NLVL-1].valid ? lvl_pick[NLVL-1] : lvl_pick[0];
    end

endmodule

// File: rtl/irqc_seq.sv
module irqc_seq
    import irqc_pkg::*;
#(
    parameter int              CALL_CYC = 4,
    parameter logic [VECW-1:0] VEC_BASE = 16'h0003,
    parameter int              VEC_STEP = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            boundary,
    input  logic            reti,
    input  pick_t           win,
    output logic [NLVL-1:0] busy_d,
    output logic [NLVL-1:0] busy_q,
    output src_vec_t        clr,
    output logic            take_o,
    output logic [VECW-1:0] vec_o,
    output logic            lvl_o,
    output logic            ret_o
);

    localparam int CW = $clog2(CALL_CYC + 1);

    sq_state_e st;
    logic [CW-1:0] cnt;
    pick_t det;
    pick_t cur;
    logic fire;
    logic start;

    assign fire  = (st == SQ_CALL) && (cnt == CW'(CALL_CYC - 1));
    assign start = (st == SQ_IDLE) && det.valid && boundary && !reti;

    always_comb begin
        busy_d = busy_q;
        if (reti) begin
            if (busy_q[1]) busy_d[1] = 1'b0;
            else           busy_d[0] = 1'b0;
        end
        if (fire) busy_d[cur.hi] = 1'b1;
    end

    always_comb begin
        clr = '0;
        if (fire) clr[cur.idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            cnt    <= '0;
            det    <= '0;
            cur    <= '0;
            busy_q <= '0;
            take_o <= 1'b0;
            vec_o  <= '0;
            lvl_o  <= 1'b0;
            ret_o  <= 1'b0;
        end else begin
            take_o <= 1'b0;
            ret_o  <= reti && (|busy_q);
            busy_q <= busy_d;
            det    <= win;
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        st  <= SQ_CALL;
                        cnt <= CW'(1);
                        cur <= det;
                    end
                end
                SQ_CALL: begin
                    if (fire) begin
                        st     <= SQ_IDLE;
                        cnt    <= '0;
                        take_o <= 1'b1;
                        vec_o  <= vec_of(cur.idx, VEC_BASE, VEC_STEP);
                        lvl_o  <= cur.hi;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int              CALL_CYC = 4,
    parameter logic [VECW-1:0] VEC_BASE = 16'h0003,
    parameter int              VEC_STEP = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [NSRC-1:0] wr_data,
    input  logic [NSRC-1:0] evt_i,
    input  logic            insn_done,
    input  logic            reti,
    output logic            take_o,
    output logic [VECW-1:0] vec_o,
    output logic            lvl_o,
    output logic [NLVL-1:0] insvc_o,
    output logic            ret_o
);

    src_vec_t pend_q, en_q, prio_q, clr, pend_eff;
    logic gie_q;
    logic [NLVL-1:0] busy_d, busy_q;
    pick_t win;

    irqc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wsel_e'(wr_sel)),
        .wr_data (wr_data),
        .evt     (evt_i),
        .clr     (clr),
        .pend_q  (pend_q),
        .en_q    (en_q),
        .prio_q  (prio_q),
        .gie_q   (gie_q)
    );

    // the flag cleared by this cycle's take must not be seen again
    assign pend_eff = pend_q & ~clr;

    irqc_arb u_arb (
        .pend (pend_eff),
        .en   (en_q),
        .prio (prio_q),
        .gie  (gie_q),
        .busy (busy_d),
        .win  (win)
    );

    irqc_seq #(
        .CALL_CYC (CALL_CYC),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .boundary (insn_done),
        .reti     (reti),
        .win      (win),
        .busy_d   (busy_d),
        .busy_q   (busy_q),
        .clr      (clr),
        .take_o   (take_o),
        .vec_o    (vec_o),
        .lvl_o    (lvl_o),
        .ret_o    (ret_o)
    );

    assign insvc_o = busy_q;

endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk
    import irqc_pkg::*;
#(
    parameter logic [VECW-1:0] VEC_BASE = 16'h0003,
    parameter int              VEC_STEP = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            reti,
    input logic            take_o,
    input logic [VECW-1:0] vec_o,
    input logic            lvl_o,
    input logic [NLVL-1:0] insvc_o,
    input logic            ret_o
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!take_o && insvc_o == '0 && !ret_o)); // R1

    AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        take_o |=> !take_o); // R3

    AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (int'(vec_o) >= int'(VEC_BASE)
                    && ((int'(vec_o) - int'(VEC_BASE)) % VEC_STEP) == 0
                    && ((int'(vec_o) - int'(VEC_BASE)) / VEC_STEP) < NSRC)); // R4

    AST_TAKE_MARKS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        take_o |-> insvc_o[lvl_o]); // R8

    AST_RET_HIGH_FIRST: assert property (@(posedge clk) disable iff (rst)
        (reti && insvc_o == 2'b11) |=> insvc_o == 2'b01); // R8

    AST_RET_ACK: assert property (@(posedge clk) disable iff (rst)
        (reti && insvc_o != '0) |=> ret_o); // R8

    AST_HIGH_NOT_PREEMPTED: assert property (@(posedge clk) disable iff (rst)
        take_o |-> !$past(insvc_o[1])); // R9

    AST_LOW_YIELDS_TO_HIGH_ONLY: assert property (@(posedge clk) disable iff (rst)
        (take_o && $past(insvc_o[0])) |-> lvl_o); // R9

endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk #(
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .reti    (reti),
    .take_o  (take_o),
    .vec_o   (vec_o),
    .lvl_o   (lvl_o),
    .insvc_o (insvc_o),
    .ret_o   (ret_o)
);

// File: tb/nest_irq_ctrl_test.sv
`timescale 1ns/1ps
module nest_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [11:0] wr_data;
    logic [11:0] evt_i;
    logic        insn_done;
    logic        reti;
    logic        take_o;
    logic [15:0] vec_o;
    logic        lvl_o;
    logic [1:0]  insvc_o;
    logic        ret_o;

    int checks = 0;
    int errors = 0;
    int k;
    logic seen;

    nest_irq_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .evt_i(evt_i), .insn_done(insn_done), .reti(reti), .take_o(take_o),
        .vec_o(vec_o), .lvl_o(lvl_o), .insvc_o(insvc_o), .ret_o(ret_o)
    );

    always #2.5 clk = ~clk;

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual hung, expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [15:0] vaddr(input int idx);
        return 16'(3 + 8 * idx);
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [11:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reset_all();
        rst = 1'b1; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
        evt_i = '0; insn_done = 1'b1; reti = 1'b0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic wait_take(input int lim, output int n);
        n = 0;
        while (n < lim && !take_o) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic no_take(input int n, output logic s);
        s = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (take_o) s = 1'b1;
        end
    endtask

    task automatic do_reti();
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    task automatic t_reset();
        reset_all();
        chk("R1", "take after reset", take_o, 0);
        chk("R1", "insvc after reset", insvc_o, 0);
        chk("R1", "ret after reset", ret_o, 0);
        wr(2'd1, 12'hFFF);
        wr(2'd3, 12'h001);
        no_take(12, seen);
        chk("R1", "take with nothing pending", seen, 0);
    endtask

    task automatic t_latency();
        reset_all();
        wr(2'd1, 12'hFFF);
        wr(2'd3, 12'h001);
        wr(2'd0, 12'h020);
        wait_take(20, k);
        chk("R3", "edges to take", k, 5);
        chk("R4", "vector src5", vec_o, vaddr(5));
        chk("R4", "level src5", lvl_o, 0);
        chk("R8", "insvc after low take", insvc_o, 2'b01);
        cyc(1);
        chk("R3", "take pulse width", take_o, 0);
        no_take(12, seen);
        chk("R7", "second take of cleared flag", seen, 0);
        do_reti();
        chk("R8", "ret ack", ret_o, 1);
        chk("R8", "insvc after return", insvc_o, 2'b00);
    endtask

    task automatic t_gating();
        reset_all();
        wr(2'd3, 12'h001);
        evt_i = 12'h004;
        cyc(1);
        evt_i = '0;
        no_take(12, seen);
        chk("R2", "take while disabled", seen, 0);
        wr(2'd1, 12'h004);
        wait_take(20, k);
        chk("R2", "kept flag taken after enable", take_o, 1);
        chk("R2", "vector src2", vec_o, vaddr(2));

        reset_all();
        wr(2'd1, 12'hFFF);
        wr(2'd0, 12'h080);
        no_take(12, seen);
        chk("R12", "take with master off", seen, 0);
        wr(2'd3, 12'h001);
        wait_take(20, k);
        chk("R12", "take after master on", take_o, 1);
        chk("R12", "vector src7", vec_o, vaddr(7));
    endtask

    task automatic t_priority();
        reset_all();
        wr(2'd1, 12'hFFF);
        wr(2'd2, 12'h200);
        wr(2'd3, 12'h001);
        wr(2'd0, 12'h208);
        wait_take(20, k);
        chk("R5", "high beats lower index", vec_o, vaddr(9));
        chk("R5", "level high", lvl_o, 1);
        no_take(12, seen);
        chk("R9", "low taken under high", seen, 0);
        do_reti();
        wait_take(20, k);
        chk("R10", "edges after return", k, 4);
        chk("R5", "low follows", vec_o, vaddr(3));
        chk("R5", "level low", lvl_o, 0);
    endtask

    task automatic t_order();
        reset_all();
        wr(2'd1, 12'hFFF);
        wr(2'd3, 12'h001);
        wr(2'd0, 12'h450);
        wait_take(20, k);
        chk("R6", "first src4", vec_o, vaddr(4));
        do_reti();
        wait_take(20, k);
        chk("R6", "second src6", vec_o, vaddr(6));
        do_reti();
        wait_take(20, k);
        chk("R6", "third src10", vec_o, vaddr(10));
    endtask

    task automatic t_nesting();
        reset_all();
        wr(2'd1, 12'hFFF);
        wr(2'd2, 12'h100);
        wr(2'd3, 12'h001);
        wr(2'd0, 12'h002);
        wait_take(20, k);
        chk("R9", "low src1 taken", vec_o, vaddr(1));
        wr(2'd0, 12'h004);
        no_take(12, seen);
        chk("R9", "low under low", seen, 0);
        wr(2'd0, 12'h104);
        wait_take(20, k);
        chk("R9", "high preempts low", vec_o, vaddr(8));
        chk("R8", "both levels in service", insvc_o, 2'b11);
        do_reti();
        chk("R8", "high cleared first", insvc_o, 2'b01);
        chk("R8", "ret ack nested", ret_o, 1);
        no_take(12, seen);
        chk("R9", "low still waits", seen, 0);
        do_reti();
        wait_take(20, k);
        chk("R9", "waiting low taken", vec_o, vaddr(2));
    endtask

    task automatic t_return_gap();
        reset_all();
        wr(2'd1, 12'hFFF);
        wr(2'd2, 12'h400);
        wr(2'd3, 12'h001);
        wr(2'd0, 12'h001);
        wait_take(20, k);
        chk("R10", "low src0 taken", vec_o, vaddr(0));
        insn_done = 1'b0;
        wr(2'd0, 12'h400);
        no_take(4, seen);
        chk("R11", "no call without boundary", seen, 0);
        reti = 1'b1; insn_done = 1'b1;
        @(negedge clk);
        reti = 1'b0; insn_done = 1'b0;
        no_take(6, seen);
        chk("R10", "return cycle starts no call", seen, 0);
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        wait_take(20, k);
        chk("R11", "edges from boundary", k, 3);
        chk("R10", "vector src10", vec_o, vaddr(10));
        chk("R8", "only high in service", insvc_o, 2'b10);
        insn_done = 1'b1;
    endtask

    task automatic t_boundary();
        reset_all();
        wr(2'd1, 12'hFFF);
        wr(2'd3, 12'h001);
        insn_done = 1'b0;
        wr(2'd0, 12'h800);
        no_take(10, seen);
        chk("R11", "held without boundary", seen, 0);
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        wait_take(20, k);
        chk("R11", "edges after boundary", k, 3);
        chk("R4", "vector src11", vec_o, vaddr(11));
        insn_done = 1'b1;
    endtask

    initial begin
        t_reset();
        t_latency();
        t_gating();
        t_priority();
        t_order();
        t_nesting();
        t_return_gap();
        t_boundary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule